// File: doc/BRIEF.md
# Address Translation Cache

This block holds a small set of recently used page table entries and turns 32-bit virtual addresses into 32-bit physical addresses in a single pass. The upper 20 bits of a virtual address select a page and the lower 12 bits are a byte offset within it. Every request compares its page number against all stored entries at once. A matching entry supplies the frame number and the permission flags. If nothing matches, the block reports a miss, and an external walker then reads the page table in memory and writes the entry back through the refill port.

Requests enter and results leave through valid/ready streams. A request is taken on a clock edge where `lk_valid` and `lk_ready` are both high. Its result appears on the next cycle and stays unchanged until `rs_ready` is seen high. `lk_ready` is high only when no flush is asserted and the result register is empty or being drained in that cycle, so back-pressure on the result stalls new requests. The refill stream gives way to a request in the same cycle and to any flush. The two flush inputs are plain single-cycle strobes. One flush is used on a context switch and spares entries marked global. The other clears everything.

Top module: `tlb_cache`

## Requirements
- R1: After reset no entry is valid, `rs_valid` is low and `lk_ready` is high.
- R2: A hit returns `rs_paddr = {frame, offset}`: bits 31:12 come from the stored entry's bits 31:12, and bits 11:0 are the request's bits 11:0.
- R3: A request whose page number matches no valid entry returns `rs_miss` with `rs_paddr` and `rs_pte` zero.
- R4: A write (`lk_write`=1) to an entry with bit 1 (writable) clear, or a user request (`lk_user`=1) to an entry with bit 2 (user) clear, returns `rs_fault` with the stored entry unchanged on `rs_pte`, and it leaves the stored entry unmodified.
- R5: A hit sets bit 5 (referenced) of the stored entry, and a write hit also sets bit 6 (dirty). `rs_pte` shows the updated entry.
- R6: A refill whose entry has bit 0 (present) clear is discarded. A refill of a page number that is already stored overwrites that slot in place, so a page number is never stored twice.
- R7: A refill of a new page number goes into the lowest-numbered invalid slot. When all slots are valid, it goes into the slot named by a rotating pointer. The pointer starts at 0 after reset and advances by one after each such replacement.
- R8: A `flush_local` pulse invalidates every entry whose bit 8 (global) is clear and keeps the rest.
- R9: A `flush_all` pulse invalidates every entry.
- R10: A result is held stable while `rs_ready` is low. `lk_ready` is low in any cycle where a flush is asserted, and `rf_ready` is low when a request is taken or a flush is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Translation request valid |
| lk_ready | output | 1 | Request can be taken |
| lk_vaddr | input | 32 | Virtual address |
| lk_write | input | 1 | Request is a write |
| lk_user | input | 1 | Request is from user mode |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Consumer takes the result |
| rs_paddr | output | 32 | Physical address on hit |
| rs_pte | output | 32 | Entry after update (hit) or as stored (fault) |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No matching entry |
| rs_fault | output | 1 | Permission violation |
| rf_valid | input | 1 | Refill entry valid |
| rf_ready | output | 1 | Refill can be taken |
| rf_vpn | input | 20 | Page number of the refill |
| rf_pte | input | 32 | Page table entry for the refill |
| flush_local | input | 1 | Invalidate non-global entries |
| flush_all | input | 1 | Invalidate all entries |

## Verification
The hardest state to reach from the ports is the rotating replacement pointer, because slot indices are never visible. The stimulus first clears the table and fills all eight slots in a known order. It then adds new page numbers and watches which older page numbers turn into misses. It also refills a page number that is already stored, to show that an in-place overwrite does not move the pointer. Proving that a fault leaves the stored entry alone works the same way: the entry is faulted twice, and the second fault must still show the referenced bit clear.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PTE_W = 32;
  localparam int PA_W  = VA_W;

  localparam int B_PRES  = 0;
  localparam int B_WR    = 1;
  localparam int B_USER  = 2;
  localparam int B_REF   = 5;
  localparam int B_DIRTY = 6;
  localparam int B_GLOB  = 8;

  typedef enum logic [1:0] {
    OUT_MISS  = 2'd0,
    OUT_HIT   = 2'd1,
    OUT_FAULT = 2'd2
  } outcome_e;

  typedef struct packed {
    logic             vld;
    logic [VPN_W-1:0] vpn;
    logic [PTE_W-1:0] pte;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  tlb_ent_t [N-1:0] ents,
  input  logic [VPN_W-1:0] key,
  output logic [N-1:0]     hit_vec,
  output logic             any,
  output logic [IW-1:0]    idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ents[g].vld && (ents[g].vpn == key);
  end

  assign any = |hit_vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) idx = IW'(i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid_vec,
  input  logic [N-1:0]  same_vec,
  input  logic          alloc,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] rr_q;
  logic [IW-1:0] same_idx, free_idx;
  logic          has_free, has_same;

  always_comb begin
    same_idx = '0;
    free_idx = '0;
    has_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IW'(i);
        has_free = 1'b1;
      end
      if (same_vec[i]) same_idx = IW'(i);
    end
    has_same = |same_vec;
    if (has_same)      idx = same_idx;
    else if (has_free) idx = free_idx;
    else               idx = rr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (alloc && !has_same && !has_free)
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  // R7
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc && !(&valid_vec) && !(|same_vec) |-> !valid_vec[idx]);
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  input  logic             lk_user,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic [PA_W-1:0]  rs_paddr,
  output logic [PTE_W-1:0] rs_pte,
  output logic             rs_hit,
  output logic             rs_miss,
  output logic             rs_fault,
  input  logic             rf_valid,
  output logic             rf_ready,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PTE_W-1:0] rf_pte,
  input  logic             flush_local,
  input  logic             flush_all
);
  tlb_ent_t [ENTRIES-1:0] ents_q;
  logic [ENTRIES-1:0] lk_vec, rf_vec, valid_vec;
  logic               lk_any, rf_any;
  logic [IW-1:0]      lk_idx, rf_idx, vic_idx;
  logic               flushing, lk_fire, rf_fire, rf_store;
  tlb_ent_t           sel;
  logic               perm_bad;
  logic [PTE_W-1:0]   upd_pte;
  outcome_e           outc, outc_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign valid_vec[g] = ents_q[g].vld;
  end

  tlb_match #(.N(ENTRIES)) i_lk_match (
    .ents(ents_q), .key(lk_vaddr[VA_W-1:OFF_W]),
    .hit_vec(lk_vec), .any(lk_any), .idx(lk_idx));

  tlb_match #(.N(ENTRIES)) i_rf_match (
    .ents(ents_q), .key(rf_vpn),
    .hit_vec(rf_vec), .any(rf_any), .idx(rf_idx));

  assign flushing = flush_local || flush_all;
  assign lk_ready = !flushing && (!rs_valid || rs_ready);
  assign lk_fire  = lk_valid && lk_ready;
  assign rf_ready = !flushing && !lk_fire;
  assign rf_fire  = rf_valid && rf_ready;
  assign rf_store = rf_fire && rf_pte[B_PRES];

  tlb_victim #(.N(ENTRIES)) i_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .same_vec(rf_vec),
    .alloc(rf_store), .idx(vic_idx));

  always_comb begin
    sel      = ents_q[lk_idx];
    perm_bad = (lk_write && !sel.pte[B_WR]) || (lk_user && !sel.pte[B_USER]);
    upd_pte  = sel.pte;
    upd_pte[B_REF] = 1'b1;
    if (lk_write) upd_pte[B_DIRTY] = 1'b1;
    if (!lk_any)       outc = OUT_MISS;
    else if (perm_bad) outc = OUT_FAULT;
    else               outc = OUT_HIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ents_q[i] <= '0;
    end else if (flush_all) begin
      for (int i = 0; i < ENTRIES; i++) ents_q[i].vld <= 1'b0;
    end else if (flush_local) begin
      for (int i = 0; i < ENTRIES; i++)
        if (!ents_q[i].pte[B_GLOB]) ents_q[i].vld <= 1'b0;
    end else begin
      if (lk_fire && outc == OUT_HIT) ents_q[lk_idx].pte <= upd_pte;
      if (rf_store) ents_q[vic_idx] <= '{vld: 1'b1, vpn: rf_vpn, pte: rf_pte};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_paddr <= '0;
      rs_pte   <= '0;
      outc_q   <= OUT_MISS;
    end else if (lk_fire) begin
      rs_valid <= 1'b1;
      outc_q   <= outc;
      rs_paddr <= (outc == OUT_HIT) ? {sel.pte[PTE_W-1:OFF_W], lk_vaddr[OFF_W-1:0]} : '0;
      rs_pte   <= (outc == OUT_HIT) ? upd_pte : (outc == OUT_FAULT) ? sel.pte : '0;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  assign rs_hit   = rs_valid && outc_q == OUT_HIT;
  assign rs_miss  = rs_valid && outc_q == OUT_MISS;
  assign rs_fault = rs_valid && outc_q == OUT_FAULT;

  // R10
  rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_paddr) && $stable(rs_pte));
  // R3
  outcome_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $countones({rs_hit, rs_miss, rs_fault}) == 1);
  // R6
  no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec));
  // R9
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_any);
  // R2
  offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> !rs_hit || rs_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));
  // R5
  ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_hit |-> rs_pte[B_REF] && rs_pte[B_PRES]);
endmodule

// File: tb/test_tlb_cache.sv
module test_tlb_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_ready, rs_valid, rs_hit, rs_miss, rs_fault, rf_ready;
  logic        rs_ready = 1'b1;
  logic [31:0] rs_paddr, rs_pte;
  logic        rf_valid = 1'b0;
  logic [19:0] rf_vpn = '0;
  logic [31:0] rf_pte = '0;
  logic        flush_local = 1'b0, flush_all = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] pa;
    logic [31:0] pte;
  } exp_t;
  localparam logic [2:0] K_HIT = 3'b100, K_MISS = 3'b010, K_FLT = 3'b001;

  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  tlb_cache i_tlb_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_paddr(rs_paddr),
    .rs_pte(rs_pte), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_fault(rs_fault),
    .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_vpn(rf_vpn), .rf_pte(rf_pte),
    .flush_local(flush_local), .flush_all(flush_all));

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: drives back-pressure and pops the scoreboard
  always @(negedge clk) begin
    cyc++;
    rs_ready = (cyc % 4) != 1;
    if (rst_n && rs_valid && rs_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected result", {29'd0, rs_hit, rs_miss, rs_fault}, '0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rs_hit, rs_miss, rs_fault} == e.kind && rs_paddr == e.pa && rs_pte == e.pte, t,
              {29'd0, rs_hit, rs_miss, rs_fault, rs_paddr, rs_pte}, {29'd0, e.kind, e.pa, e.pte});
      end
    end
  end

  task automatic lookup(input logic [31:0] va, input logic wr, input logic us,
                        input logic [2:0] kind, input logic [31:0] pa, input logic [31:0] pte,
                        input string req);
    exp_q.push_back('{kind: kind, pa: pa, pte: pte});
    tag_q.push_back(req);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_user = us;
    #2;
    while (!lk_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1 lk_valid = 1'b0;
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [31:0] pte);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = vpn; rf_pte = pte;
    #2;
    check(rf_ready == 1'b1, "R10 rf_ready idle", {95'd0, rf_ready}, 96'd1);
    @(posedge clk);
    #1 rf_valid = 1'b0;
  endtask

  task automatic flush(input bit all);
    @(negedge clk);
    if (all) flush_all = 1'b1; else flush_local = 1'b1;
    #2;
    check(lk_ready == 1'b0 && rf_ready == 1'b0, "R10 ready low in flush",
          {94'd0, lk_ready, rf_ready}, 96'd0);
    @(posedge clk);
    #1 begin flush_all = 1'b0; flush_local = 1'b0; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 96'd0, 96'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R1 reset state
    check(rs_valid == 1'b0 && lk_ready == 1'b1, "R1 reset", {94'd0, rs_valid, lk_ready}, 96'd1);

    lookup(32'h11111222, 0, 1, K_MISS, 32'h0, 32'h0, "R3 empty miss");
    lookup(32'h11111222, 0, 0, K_MISS, 32'h0, 32'h0, "R1 nothing valid");
    refill(20'h11111, 32'hABCDE007);
    lookup(32'h11111222, 0, 1, K_HIT, 32'hABCDE222, 32'hABCDE027, "R2 hit paddr");
    lookup(32'h11111FFF, 1, 1, K_HIT, 32'hABCDEFFF, 32'hABCDE067, "R5 write sets dirty");
    lookup(32'h11111000, 0, 1, K_HIT, 32'hABCDE000, 32'hABCDE067, "R5 dirty kept");
    lookup(32'h11112000, 0, 1, K_MISS, 32'h0, 32'h0, "R3 neighbour miss");

    refill(20'h22222, 32'h12345001);
    lookup(32'h22222010, 0, 1, K_FLT, 32'h0, 32'h12345001, "R4 user fault");
    lookup(32'h22222010, 0, 1, K_FLT, 32'h0, 32'h12345001, "R4 fault left entry");
    lookup(32'h22222010, 1, 0, K_FLT, 32'h0, 32'h12345001, "R4 write fault");
    lookup(32'h22222010, 0, 0, K_HIT, 32'h12345010, 32'h12345021, "R4 supervisor read");

    refill(20'h33333, 32'h00333107);
    flush(1'b0);
    lookup(32'h11111222, 0, 1, K_MISS, 32'h0, 32'h0, "R8 local gone");
    lookup(32'h22222000, 0, 0, K_MISS, 32'h0, 32'h0, "R8 local gone 2");
    lookup(32'h33333444, 0, 1, K_HIT, 32'h00333444, 32'h00333127, "R8 global kept");
    flush(1'b1);
    lookup(32'h33333444, 0, 1, K_MISS, 32'h0, 32'h0, "R9 global cleared");

    refill(20'h44444, 32'h44444006);
    lookup(32'h44444000, 0, 1, K_MISS, 32'h0, 32'h0, "R6 not present ignored");

    for (int i = 0; i < 8; i++) refill(20'h00100 + 20'(i), ((32'h200 + i) << 12) | 32'h7);
    for (int i = 0; i < 8; i++)
      lookup(((32'h100 + i) << 12) | 32'hAB, 0, 1, K_HIT,
             ((32'h200 + i) << 12) | 32'hAB, ((32'h200 + i) << 12) | 32'h27, "R7 full table");
    refill(20'h00500, 32'h00900007);
    lookup(32'h00100000, 0, 1, K_MISS, 32'h0, 32'h0, "R7 slot0 replaced");
    lookup(32'h00500001, 0, 1, K_HIT, 32'h00900001, 32'h00900027, "R7 new entry");
    lookup(32'h00101001, 0, 1, K_HIT, 32'h00201001, 32'h00201027, "R7 slot1 kept");
    refill(20'h00501, 32'h00901007);
    lookup(32'h00101000, 0, 1, K_MISS, 32'h0, 32'h0, "R7 slot1 replaced");
    refill(20'h00102, 32'h00777007);
    lookup(32'h00102005, 0, 1, K_HIT, 32'h00777005, 32'h00777027, "R6 overwrite in place");
    lookup(32'h00103005, 0, 1, K_HIT, 32'h00203005, 32'h00203027, "R6 neighbour intact");
    refill(20'h00502, 32'h00902007);
    lookup(32'h00102005, 0, 1, K_MISS, 32'h0, 32'h0, "R7 pointer after overwrite");
    lookup(32'h00103005, 0, 1, K_HIT, 32'h00203005, 32'h00203027, "R7 slot3 kept");

    wait (exp_q.size() == 0);
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule